// File: doc/BRIEF.md
# Bridge Channel Status Register

This block holds the 16-bit read-only status word of one bridge channel that moves isochronous packets in both directions. Two activity flags follow start and stop command pulses from a control register, one for the transmit side and one for the receive side. Three header-tracking flags watch a per-packet strobe that carries the packet's 2-bit EMI field and its odd/even key bit. One flag marks the first packet of a receive session. The other two mark a change in either field against the packet accepted just before it.

Error strobes from the packet parser are captured into sticky flags. Other logic supplies the buffer full and empty levels, and these are sampled into the word. A read that hits the register address returns the word one cycle later and clears every sticky flag. If an event arrives in the same cycle as the clearing read, the event is kept.

Top module: `bridge_chan_status`

## Requirements
- R1: While reset is held, rd_data is 0. A read issued on the first clock edge after reset is released returns 16'h0008, whatever the buffer level inputs are.
- R2: A read with rd_en=1 and rd_addr equal to REG_ADDR (default 8'h4E) puts the status word on rd_data in the following cycle. In every other cycle rd_data is 0. Bit 9 always reads 0.
- R3: Bit 15 (transmit active) becomes 1 after a tx_start pulse and 0 after a tx_end pulse. When both pulses arrive in the same cycle, the bit becomes 0.
- R4: Bit 14 (receive active) becomes 1 after an rx_start pulse and 0 after an rx_end pulse. When both pulses arrive in the same cycle, the bit becomes 0.
- R5: Bit 13 sets on the first hdr_vld that is accepted after an rx_start. Later accepted packets in the same session do not set it again.
- R6: Bit 12 sets when an accepted packet's hdr_emi differs from the hdr_emi of the previously accepted packet in the same session.
- R7: Bit 11 sets when an accepted packet's hdr_oe differs from the hdr_oe of the previously accepted packet in the same session.
- R8: A hdr_vld is accepted only while bit 14 is already 1. A strobe that is not accepted sets no flag and does not change the stored previous header. The first accepted packet of a session never sets bit 12 or bit 11.
- R9: Each err_evt bit sets its own sticky flag: bit 0 sets status bit 0, bit 1 sets bit 1, bit 2 sets bit 2, bit 3 sets bit 5, bit 4 sets bit 6, bit 5 sets bit 7, bit 6 sets bit 8, and bit 7 sets bit 10.
- R10: A read that hits the address clears bits 13..10, 8..5 and 2..0 after it samples them. If a set event occurs in the same cycle as the read, that flag is 1 afterwards. A read to any other address clears nothing.
- R11: Bit 4 equals fifo_full and bit 3 equals fifo_empty as sampled on the previous clock edge. A read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Transmit start command pulse |
| tx_end | input | 1 | Transmit stop command pulse |
| rx_start | input | 1 | Receive start command pulse |
| rx_end | input | 1 | Receive stop command pulse |
| hdr_vld | input | 1 | One-cycle strobe per received isochronous packet header |
| hdr_emi | input | EMI_W (2) | EMI field of the header |
| hdr_oe | input | 1 | Odd/even key bit of the header |
| err_evt | input | 8 | Error strobes, mapped as in R9 |
| fifo_full | input | 1 | Buffer full level |
| fifo_empty | input | 1 | Buffer empty level |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | 16 | Read data, valid the cycle after a hit |

## Verification
Every result of this block is due exactly one clock edge after its cause. A command pulse, header strobe or error strobe changes the stored state at the next edge. A read hit captures that state onto rd_data at its own edge, so a read placed the cycle after a stimulus shows the stimulus. Read-side clearing and a same-cycle set both take effect at the read's edge. The bench's behavioural model advances at each rising edge from the inputs the bench drove at the previous falling edge. It compares its expected rd_data with the port at every falling edge, so each comparison falls half a cycle after the edge that produced the value.

// File: rtl/bcs_pkg.sv
// Package: shared layout of the bridge channel status word.
// Assumes: field order below is the software-visible bit order (bit 15 first).
package bcs_pkg;

    // Status word, most significant field first.
    typedef struct packed {
        logic tx_active;     // 15
        logic rx_active;     // 14
        logic first_pkt;     // 13
        logic emi_chg;       // 12
        logic oe_chg;        // 11
        logic len_err;       // 10
        logic rsvd;          // 9
        logic tx_late;       // 8
        logic rx_late;       // 7
        logic size56_err;    // 6
        logic subtype_err;   // 5
        logic buf_full;      // 4
        logic buf_empty;     // 3
        logic blkcnt_err;    // 2
        logic cmnhdr_err;    // 1
        logic fmtcode_err;   // 0
    } status_t;

    localparam int ERR_N  = 8;           // number of error strobes
    localparam int HDR_N  = 3;           // header-tracking flags
    localparam int STK_N  = ERR_N + HDR_N;

endpackage

// File: rtl/bcs_busy_flag.sv
// Module: one command-driven activity flag.
// Assumes: start and stop are single-cycle pulses; stop wins on a collision.
module bcs_busy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic active
);

    // Set on start, clear on stop, stop has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= 1'b0;
        else if (stop)   active <= 1'b0;
        else if (start)  active <= 1'b1;
    end

    // R3 R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !active);

    // R3 R4
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> active);

endmodule

// File: rtl/bcs_hdr_track.sv
// Module: compares each accepted packet header with the previous one.
// Assumes: hdr_vld is a one-cycle strobe; packets count only while the
// receive side is active; a new session forgets the previous header.
module bcs_hdr_track #(
    parameter int EMI_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_start,
    input  logic             rx_active,
    input  logic             hdr_vld,
    input  logic [EMI_W-1:0] hdr_emi,
    input  logic             hdr_oe,
    output logic             first_evt,
    output logic             emi_evt,
    output logic             oe_evt
);

    logic             seen;
    logic             prev_ok;
    logic [EMI_W-1:0] prev_emi;
    logic             prev_oe;
    logic             accept;

    // Event decode from the current strobe and the stored header.
    always_comb begin
        accept    = hdr_vld && rx_active;
        first_evt = accept && !seen;
        emi_evt   = accept && prev_ok && (hdr_emi != prev_emi);
        oe_evt    = accept && prev_ok && (hdr_oe  != prev_oe);
    end

    // Keep the last accepted header; a session start invalidates it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            prev_ok  <= 1'b0;
            prev_emi <= '0;
            prev_oe  <= 1'b0;
        end else if (sess_start) begin
            seen    <= 1'b0;
            prev_ok <= 1'b0;
        end else if (accept) begin
            seen     <= 1'b1;
            prev_ok  <= 1'b1;
            prev_emi <= hdr_emi;
            prev_oe  <= hdr_oe;
        end
    end

    // R8
    first_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_evt |-> !(emi_evt || oe_evt));

    // R8
    idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> !(first_evt || emi_evt || oe_evt));

    // R5
    one_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_evt && !sess_start) |=> !first_evt);

endmodule

// File: rtl/bcs_sticky.sv
// Module: bank of sticky flags cleared by a read, set-wins on collision.
// Assumes: clr is a single-cycle read strobe.
module bcs_sticky #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);

    // Clear on read, then merge new events so none is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set;
    end

    // R10
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((q & ~$past(set)) == '0));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/bridge_chan_status.sv
// Module: top of the bridge channel status register.
// Assumes: all inputs are synchronous to clk; rd_data is registered and
// reads 0 outside the cycle after an address hit.
module bridge_chan_status #(
    parameter int          EMI_W    = 2,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h4E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              tx_end,
    input  logic              rx_start,
    input  logic              rx_end,
    input  logic              hdr_vld,
    input  logic [EMI_W-1:0]  hdr_emi,
    input  logic              hdr_oe,
    input  logic [7:0]        err_evt,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data
);
    import bcs_pkg::*;

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic               tx_active, rx_active;
    logic               first_evt, emi_evt, oe_evt;
    logic [STK_N-1:0]   stk_set, stk_q;
    logic               full_q, empty_q;
    logic               rd_hit;
    status_t            word;

    bcs_busy_flag u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .stop(tx_end), .active(tx_active));

    bcs_busy_flag u_rx (
        .clk(clk), .rst_n(rst_n), .start(rx_start), .stop(rx_end), .active(rx_active));

    bcs_hdr_track #(.EMI_W(EMI_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .sess_start(rx_start), .rx_active(rx_active),
        .hdr_vld(hdr_vld), .hdr_emi(hdr_emi), .hdr_oe(hdr_oe),
        .first_evt(first_evt), .emi_evt(emi_evt), .oe_evt(oe_evt));

    // Sticky set vector: header flags on top, error strobes below.
    assign stk_set = {first_evt, emi_evt, oe_evt, err_evt};
    assign rd_hit  = rd_en && (rd_addr == HIT_ADDR);

    bcs_sticky #(.N(STK_N)) u_stk (
        .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(rd_hit), .q(stk_q));

    // Sample buffer levels; empty comes out of reset as 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            full_q  <= fifo_full;
            empty_q <= fifo_empty;
        end
    end

    // Assemble the status word from its sources.
    always_comb begin
        word.tx_active   = tx_active;
        word.rx_active   = rx_active;
        word.first_pkt   = stk_q[10];
        word.emi_chg     = stk_q[9];
        word.oe_chg      = stk_q[8];
        word.len_err     = stk_q[7];
        word.rsvd        = 1'b0;
        word.tx_late     = stk_q[6];
        word.rx_late     = stk_q[5];
        word.size56_err  = stk_q[4];
        word.subtype_err = stk_q[3];
        word.buf_full    = full_q;
        word.buf_empty   = empty_q;
        word.blkcnt_err  = stk_q[2];
        word.cmnhdr_err  = stk_q[1];
        word.fmtcode_err = stk_q[0];
    end

    // Registered read port; zero when not addressed.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_hit) rd_data <= word;
        else             rd_data <= '0;
    end

    // R2
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (rd_data == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[9] == 1'b0);

    // R11
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (rd_data[4] == $past(full_q)) && (rd_data[3] == $past(empty_q)));

endmodule

// File: tb/tb_bridge_chan_status.sv
`timescale 1ns/1ps
module tb_bridge_chan_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 0, tx_end = 0, rx_start = 0, rx_end = 0;
    logic        hdr_vld = 0;
    logic [1:0]  hdr_emi = 0;
    logic        hdr_oe = 0;
    logic [7:0]  err_evt = 0;
    logic        fifo_full = 1, fifo_empty = 0;
    logic        rd_en = 0;
    logic [7:0]  rd_addr = 0;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    bridge_chan_status dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
        .rx_start(rx_start), .rx_end(rx_end), .hdr_vld(hdr_vld),
        .hdr_emi(hdr_emi), .hdr_oe(hdr_oe), .err_evt(err_evt),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data));

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    done = 0;

    // Behavioural reference state
    bit        m_tx, m_rx, m_seen, m_pv, m_poe, m_ff, m_fe;
    int        m_pemi;
    bit [15:0] m_stk;
    bit [15:0] exp_rd;

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: rd_data got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit        hit, acc;
        bit [15:0] s, setv;
        if (!rst_n) begin
            m_tx = 0; m_rx = 0; m_seen = 0; m_pv = 0; m_pemi = 0; m_poe = 0;
            m_stk = 0; m_ff = 0; m_fe = 1; exp_rd = 0;
        end else begin
            hit = rd_en && (rd_addr == 8'h4E);
            s = m_stk;
            s[15] = m_tx; s[14] = m_rx; s[4] = m_ff; s[3] = m_fe;
            exp_rd = hit ? s : 16'h0;
            acc  = hdr_vld && m_rx;
            setv = 0;
            if (acc && !m_seen) setv[13] = 1;
            if (acc && m_pv && (int'(hdr_emi) != m_pemi)) setv[12] = 1;
            if (acc && m_pv && (hdr_oe != m_poe)) setv[11] = 1;
            setv[0] = err_evt[0]; setv[1] = err_evt[1]; setv[2] = err_evt[2];
            setv[5] = err_evt[3]; setv[6] = err_evt[4]; setv[7] = err_evt[5];
            setv[8] = err_evt[6]; setv[10] = err_evt[7];
            if (hit) m_stk = 0;
            m_stk |= setv;
            if (rx_start) begin m_seen = 0; m_pv = 0; end
            else if (acc) begin m_seen = 1; m_pv = 1; m_pemi = int'(hdr_emi); m_poe = hdr_oe; end
            if (tx_end) m_tx = 0; else if (tx_start) m_tx = 1;
            if (rx_end) m_rx = 0; else if (rx_start) m_rx = 1;
            m_ff = fifo_full; m_fe = fifo_empty;
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) if (!done) check(cur_req, rd_data, exp_rd);

    task automatic cyc(); @(negedge clk); endtask

    task automatic rd(logic [7:0] a);
        rd_en = 1; rd_addr = a; cyc(); rd_en = 0; rd_addr = 0;
    endtask

    task automatic pkt(logic [1:0] e, logic o);
        hdr_vld = 1; hdr_emi = e; hdr_oe = o; cyc(); hdr_vld = 0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) cyc();
        check("R1", rd_data, 16'h0000);
        rst_n = 1; rd_en = 1; rd_addr = 8'h4E; cyc(); rd_en = 0;
        check("R1", rd_data, 16'h0008);
        fifo_full = 0; fifo_empty = 1; cyc();

        cur_req = "R3";
        tx_start = 1; cyc(); tx_start = 0; rd(8'h4E);
        check("R3", rd_data, 16'h8008);
        tx_end = 1; cyc(); tx_end = 0; rd(8'h4E);
        tx_start = 1; cyc(); tx_start = 0;
        tx_start = 1; tx_end = 1; cyc(); tx_start = 0; tx_end = 0; rd(8'h4E);
        check("R3", rd_data, 16'h0008);

        cur_req = "R8";
        pkt(2'd1, 1'b1); rd(8'h4E);
        check("R8", rd_data, 16'h0008);

        cur_req = "R4";
        rx_start = 1; rx_end = 1; cyc(); rx_start = 0; rx_end = 0; rd(8'h4E);
        rx_start = 1; cyc(); rx_start = 0; rd(8'h4E);
        check("R4", rd_data, 16'h4008);

        cur_req = "R5";
        pkt(2'd0, 1'b0); rd(8'h4E);
        check("R5", rd_data, 16'h6008);
        pkt(2'd0, 1'b0); rd(8'h4E);
        check("R5", rd_data, 16'h4008);

        cur_req = "R6";
        pkt(2'd3, 1'b0); rd(8'h4E);
        check("R6", rd_data, 16'h5008);
        cur_req = "R7";
        pkt(2'd3, 1'b1); rd(8'h4E);
        check("R7", rd_data, 16'h4808);

        cur_req = "R8";
        rx_end = 1; cyc(); rx_end = 0;
        pkt(2'd1, 1'b0); rd(8'h4E);
        check("R8", rd_data, 16'h0008);
        rx_start = 1; cyc(); rx_start = 0;
        pkt(2'd2, 1'b0); rd(8'h4E);
        check("R8", rd_data, 16'h6008);

        cur_req = "R9";
        for (int i = 0; i < 8; i++) begin
            err_evt = 8'(1 << i); cyc(); err_evt = 0; rd(8'h4E);
        end

        cur_req = "R10";
        err_evt = 8'h80; cyc(); err_evt = 0;
        rd(8'h4F);
        check("R10", rd_data, 16'h0000);
        rd_en = 1; rd_addr = 8'h4E; err_evt = 8'h01; cyc();
        rd_en = 0; err_evt = 0;
        check("R10", rd_data, 16'h4408);
        rd(8'h4E);
        check("R10", rd_data, 16'h4009);

        cur_req = "R11";
        fifo_full = 1; fifo_empty = 0; cyc(); rd(8'h4E);
        check("R11", rd_data, 16'h4010);
        rd(8'h4E);
        check("R11", rd_data, 16'h4010);

        cur_req = "R2";
        for (int k = 0; k < 2000; k++) begin
            tx_start = ($urandom % 16) == 0; tx_end = ($urandom % 16) == 0;
            rx_start = ($urandom % 20) == 0; rx_end = ($urandom % 24) == 0;
            hdr_vld = ($urandom % 3) == 0; hdr_emi = 2'($urandom); hdr_oe = 1'($urandom);
            err_evt = (($urandom % 8) == 0) ? 8'($urandom) : 8'h0;
            fifo_full = 1'($urandom); fifo_empty = 1'($urandom);
            rd_en = ($urandom % 3) == 0;
            rd_addr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h4E;
            cyc();
        end
        {tx_start, tx_end, rx_start, rx_end, hdr_vld, rd_en} = '0;
        err_evt = 0; cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule